// File: doc/BRIEF.md
# Baseband Sample Output Formatter

This block takes one pair of wide two's-complement filter results (an I sample and a Q sample) per strobe and re-expresses each one in an output format picked by a configuration input. The formats are a compact 12-bit floating-point word, made of a 4-bit shift count and an 8-bit signed mantissa, and fixed-point words of 32, 24, 16 or 8 bits. The 24-bit and 16-bit words are rounded. The 32-bit and 8-bit words are truncated. Every formatted word sits MSB-aligned in a 32-bit result, and the unused low bits are zero.

The captured results are held for a parallel port. There, a 3-bit select picks the I or Q result and its upper or lower 16-bit half, and a ready flag pulses once per capture. When serial output is enabled, the same capture also starts a serial transfer of the I word and then the Q word. The transfer has its own bit clock, and a frame sync precedes each word. The bit clock, the frame sync and the ready flag each have a polarity input.

Top module: `sample_fmt_out`

## Requirements
- R1: Format code 0 (float) gives result bits [31:28] = exponent, [27:20] = signed mantissa and [19:0] = 0. The exponent is the number of left shifts applied to the input until its two top bits differ, capped at 15. The mantissa is the top 8 bits of the shifted input, truncated, so its two top bits differ whenever the exponent is below 15.
- R2: Format code 1 gives the top 32 input bits, truncated.
- R3: Format codes 2 (24-bit) and 3 (16-bit) round half up by adding half an output LSB before dropping the low bits. A positive input that would round past the largest positive code gives that largest code instead. The rounded value is placed in result bits [31:8] or [31:16] respectively, and the lower bits are zero.
- R4: Format code 4 gives the top 8 input bits, truncated, in result bits [31:24]; the remaining bits are zero.
- R5: Format codes 5, 6 and 7 give an all-zero result.
- R6: Results are captured on a clock edge where `in_vld` is high. The raw ready flag is active for exactly the following cycle. The results hold until the next capture. `psel` 0 selects I[31:16], 1 selects I[15:0], 2 selects Q[31:16] and 3 selects Q[15:0]; 4 to 7 drive zero.
- R7: A capture with serial enabled sends the I word and then the Q word, MSB first, on `sdat`. Word length is 12, 32, 24, 16 or 8 bits for codes 0 to 4 and 8 bits for codes 5 to 7. One bit period lasts two clocks: the raw bit clock is low in the first clock and high in the second. The raw frame sync is high for exactly one bit period just before each word, and `sdat` is 0 outside data bits.
- R8: `sck_pol`, `fs_pol` and `rdy_pol` each invert their pin when 1. With no transfer running, the raw bit clock and the raw frame sync are low.
- R9: With `ser_en` low, a capture starts no transfer. A capture while a transfer is running leaves that transfer unchanged and still updates the parallel results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Capture strobe for the I/Q pair |
| in_i | input | IN_W | In-phase filter result, two's complement |
| in_q | input | IN_W | Quadrature filter result, two's complement |
| fmt_sel | input | 3 | Output format code |
| ser_en | input | 1 | Enables the serial transfer on capture |
| sck_pol | input | 1 | Inverts the serial bit clock when 1 |
| fs_pol | input | 1 | Inverts the frame sync when 1 |
| rdy_pol | input | 1 | Inverts the ready flag when 1 |
| psel | input | 3 | Parallel word select |
| pout | output | 16 | Selected 16-bit half of a held result |
| rdy | output | 1 | Ready flag, one cycle per capture |
| sck | output | 1 | Serial bit clock |
| sfs | output | 1 | Serial frame sync |
| sdat | output | 1 | Serial data, MSB first |

## Verification
The hardest case to reach from the ports is the pair of rounding boundaries. One is a positive input whose upper bits already hold the largest code, so that adding half an LSB would carry into the sign bit. The other is an input whose dropped bits equal exactly one half. The bench forms these inputs directly around each format's rounding position and sweeps them, along with normalization extremes and pseudo-random values, through every format code. A second hard case is a new capture that lands in the middle of a serial transfer. The bench drives it partway through a frame and compares every half bit period of the running transfer against the original word.

// File: rtl/fmt_pkg.sv
package fmt_pkg;

  typedef enum logic [2:0] {
    FMT_FLT  = 3'd0,
    FMT_FX32 = 3'd1,
    FMT_FX24 = 3'd2,
    FMT_FX16 = 3'd3,
    FMT_FX8  = 3'd4
  } fmt_e;

  localparam int WORD_W = 32;
  localparam int LEN_W  = 6;

  // serial word length for a format code
  function automatic logic [LEN_W-1:0] fmt_len(input logic [2:0] code);
    case (code)
      3'd0:    return LEN_W'(12);
      3'd1:    return LEN_W'(32);
      3'd2:    return LEN_W'(24);
      3'd3:    return LEN_W'(16);
      default: return LEN_W'(8);
    endcase
  endfunction

endpackage

// File: rtl/fmt_conv.sv
module fmt_conv
  import fmt_pkg::*;
#(
  parameter int IN_W = 36
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [IN_W-1:0]     smp,
  input  logic [2:0]          fmt,
  output logic [WORD_W-1:0]   word
);

  localparam int DROP24 = IN_W - 24;
  localparam int DROP16 = IN_W - 16;

  // round half up at bit position drop, saturating on positive overflow
  function automatic logic [IN_W-1:0] round_at(input logic [IN_W-1:0] v, input int drop);
    logic [IN_W:0] half;
    logic [IN_W:0] sum;
    half = (IN_W+1)'(1) << (drop - 1);
    sum  = {v[IN_W-1], v} + half;
    if (!v[IN_W-1] && sum[IN_W-1])
      return {1'b0, {(IN_W-1){1'b1}}};
    return sum[IN_W-1:0];
  endfunction

  // count redundant sign bits, capped at 15
  function automatic logic [3:0] norm_shift(input logic [IN_W-1:0] v);
    logic [3:0] s;
    logic       stop;
    s    = 4'd0;
    stop = 1'b0;
    for (int k = 0; k < 15; k++) begin
      if (!stop && (v[IN_W-2-k] == v[IN_W-1])) s = s + 4'd1;
      else stop = 1'b1;
    end
    return s;
  endfunction

  function automatic logic [11:0] to_float(input logic [IN_W-1:0] v);
    logic [3:0]      e;
    logic [IN_W-1:0] sh;
    e  = norm_shift(v);
    sh = v << e;
    return {e, sh[IN_W-1 -: 8]};
  endfunction

  logic [IN_W-1:0] r24_full, r16_full;
  logic [23:0]     r24;
  logic [15:0]     r16;
  logic [11:0]     flt;

  assign r24_full = round_at(smp, DROP24);
  assign r16_full = round_at(smp, DROP16);
  assign r24      = r24_full[IN_W-1 -: 24];
  assign r16      = r16_full[IN_W-1 -: 16];
  assign flt      = to_float(smp);

  always_comb begin
    case (fmt)
      FMT_FLT:  word = {flt, 20'd0};
      FMT_FX32: word = smp[IN_W-1 -: 32];
      FMT_FX24: word = {r24, 8'd0};
      FMT_FX16: word = {r16, 16'd0};
      FMT_FX8:  word = {smp[IN_W-1 -: 8], 24'd0};
      default:  word = '0;
    endcase
  end

  AST_MANT_NORM: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt == FMT_FLT && word[31:28] != 4'hF) |-> (word[27] != word[26])); // R1

  AST_ROUND_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp[IN_W-1] && (fmt == FMT_FX16 || fmt == FMT_FX24)) |-> !word[31]); // R3

endmodule

// File: rtl/fmt_ser.sv
module fmt_ser
  import fmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] word_a,
  input  logic [WORD_W-1:0] word_b,
  input  logic [LEN_W-1:0]  nbits,
  output logic              sck_raw,
  output logic              fs_raw,
  output logic              sd,
  output logic              busy
);

  logic              ph;
  logic              second;
  logic [LEN_W-1:0]  cnt;
  logic [LEN_W-1:0]  len_q;
  logic [WORD_W-1:0] sh;
  logic [WORD_W-1:0] hold;
  logic              start_ok;

  assign start_ok = start && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      ph     <= 1'b0;
      second <= 1'b0;
      cnt    <= '0;
      len_q  <= '0;
      sh     <= '0;
      hold   <= '0;
    end else if (start_ok) begin
      busy   <= 1'b1;
      ph     <= 1'b0;
      second <= 1'b0;
      cnt    <= '0;
      len_q  <= nbits;
      sh     <= word_a;
      hold   <= word_b;
    end else if (busy) begin
      ph <= ~ph;
      if (ph) begin
        if (cnt == len_q) begin
          if (!second) begin
            second <= 1'b1;
            cnt    <= '0;
            sh     <= hold;
          end else begin
            busy <= 1'b0;
          end
        end else begin
          if (cnt != '0) sh <= sh << 1;
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign sck_raw = busy && ph;
  assign fs_raw  = busy && (cnt == '0);
  assign sd      = busy && (cnt != '0) && sh[WORD_W-1];

  AST_FS_ONE_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_raw && $past(fs_raw)) |=> !fs_raw); // R7

  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (hold == $past(hold))); // R9

endmodule

// File: rtl/sample_fmt_out.sv
module sample_fmt_out
  import fmt_pkg::*;
#(
  parameter int IN_W = 36,
  parameter int PW   = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_vld,
  input  logic [IN_W-1:0] in_i,
  input  logic [IN_W-1:0] in_q,
  input  logic [2:0]      fmt_sel,
  input  logic            ser_en,
  input  logic            sck_pol,
  input  logic            fs_pol,
  input  logic            rdy_pol,
  input  logic [2:0]      psel,
  output logic [PW-1:0]   pout,
  output logic            rdy,
  output logic            sck,
  output logic            sfs,
  output logic            sdat
);

  localparam int NCH = 2;

  logic [IN_W-1:0]   smp_arr [NCH];
  logic [WORD_W-1:0] word_c  [NCH];
  logic [WORD_W-1:0] word_q  [NCH];
  logic              rdy_raw;
  logic              sck_raw, fs_raw, sd_raw, ser_busy;

  assign smp_arr[0] = in_i;
  assign smp_arr[1] = in_q;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    fmt_conv #(.IN_W(IN_W)) u_conv (
      .clk  (clk),
      .rst_n(rst_n),
      .smp  (smp_arr[ch]),
      .fmt  (fmt_sel),
      .word (word_c[ch])
    );

    always_ff @(posedge clk) begin
      if (!rst_n)      word_q[ch] <= '0;
      else if (in_vld) word_q[ch] <= word_c[ch];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdy_raw <= 1'b0;
    else        rdy_raw <= in_vld;
  end

  always_comb begin
    case (psel)
      3'd0:    pout = word_q[0][WORD_W-1 -: PW];
      3'd1:    pout = word_q[0][PW-1:0];
      3'd2:    pout = word_q[1][WORD_W-1 -: PW];
      3'd3:    pout = word_q[1][PW-1:0];
      default: pout = '0;
    endcase
  end

  fmt_ser u_ser (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (in_vld && ser_en),
    .word_a (word_c[0]),
    .word_b (word_c[1]),
    .nbits  (fmt_len(fmt_sel)),
    .sck_raw(sck_raw),
    .fs_raw (fs_raw),
    .sd     (sd_raw),
    .busy   (ser_busy)
  );

  assign rdy  = rdy_raw ^ rdy_pol;
  assign sck  = sck_raw ^ sck_pol;
  assign sfs  = fs_raw ^ fs_pol;
  assign sdat = sd_raw;

  AST_RDY_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_raw |-> $past(in_vld)); // R6

  AST_WORDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_vld) |-> (word_q[0] == $past(word_q[0]) && word_q[1] == $past(word_q[1]))); // R6

  AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_busy |-> (!sck_raw && !fs_raw && !sd_raw)); // R8

endmodule

// File: tb/sample_fmt_out_tb.sv
module sample_fmt_out_tb;

  localparam int IN_W = 36;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_vld = 1'b0;
  logic [IN_W-1:0] in_i = '0, in_q = '0;
  logic [2:0]      fmt_sel = 3'd0;
  logic            ser_en = 1'b0, sck_pol = 1'b0, fs_pol = 1'b0, rdy_pol = 1'b0;
  logic [2:0]      psel = 3'd0;
  logic [15:0]     pout;
  logic            rdy, sck, sfs, sdat;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sample_fmt_out #(.IN_W(IN_W), .PW(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_i(in_i), .in_q(in_q),
    .fmt_sel(fmt_sel), .ser_en(ser_en), .sck_pol(sck_pol), .fs_pol(fs_pol),
    .rdy_pol(rdy_pol), .psel(psel), .pout(pout), .rdy(rdy), .sck(sck),
    .sfs(sfs), .sdat(sdat)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input int f);
    case (f)
      0: return "R1";
      1: return "R2";
      2, 3: return "R3";
      4: return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic logic [31:0] rnd_model(input logic [IN_W-1:0] v, input int n);
    longint x, r, mx;
    int d;
    d  = IN_W - n;
    x  = longint'($signed(v));
    r  = (x + (longint'(1) << (d - 1))) >>> d;
    mx = (longint'(1) << (n - 1)) - 1;
    if (r > mx) r = mx;
    return 32'(r) << (32 - n);
  endfunction

  function automatic logic [31:0] exp_word(input int f, input logic [IN_W-1:0] v);
    logic [IN_W-1:0] y;
    int s;
    case (f)
      0: begin
        y = v; s = 0;
        while (s < 15 && y[IN_W-1] == y[IN_W-2]) begin y = y << 1; s++; end
        return {s[3:0], y[IN_W-1 -: 8], 20'd0};
      end
      1: return v[IN_W-1 -: 32];
      2: return rnd_model(v, 24);
      3: return rnd_model(v, 16);
      4: return {v[IN_W-1 -: 8], 24'd0};
      default: return 32'd0;
    endcase
  endfunction

  function automatic int slen(input int f);
    case (f)
      0: return 12; 1: return 32; 2: return 24; 3: return 16;
      default: return 8;
    endcase
  endfunction

  // parallel capture and readback of all select codes
  task automatic par_check(input int f, input logic [IN_W-1:0] vi, input logic [IN_W-1:0] vq);
    logic [31:0] wi, wq;
    logic [15:0] e;
    wi = exp_word(f, vi);
    wq = exp_word(f, vq);
    fmt_sel = 3'(f); in_i = vi; in_q = vq; in_vld = 1'b1;
    @(negedge clk);
    in_vld = 1'b0;
    chk("R6", "rdy active", rdy, !rdy_pol);
    for (int s = 0; s < 8; s++) begin
      psel = 3'(s);
      #1;
      case (s)
        0: e = wi[31:16];
        1: e = wi[15:0];
        2: e = wq[31:16];
        3: e = wq[15:0];
        default: e = 16'd0;
      endcase
      chk(s < 4 ? req_of(f) : "R6", $sformatf("fmt %0d psel %0d", f, s), pout, e);
    end
    @(negedge clk);
    chk("R6", "rdy one cycle", rdy, rdy_pol);
  endtask

  // serial transfer check, optional second capture at cycle inj
  task automatic ser_check(input int f, input logic [IN_W-1:0] vi, input logic [IN_W-1:0] vq,
                           input int inj, input logic [IN_W-1:0] vnew);
    logic [31:0] w [2];
    int n, total, p, q, wd;
    w[0] = exp_word(f, vi);
    w[1] = exp_word(f, vq);
    n = slen(f);
    total = 4 * (n + 1);
    fmt_sel = 3'(f); in_i = vi; in_q = vq; ser_en = 1'b1; in_vld = 1'b1;
    @(negedge clk);
    in_vld = 1'b0;
    for (int c = 0; c < total; c++) begin
      p  = c / 2;
      wd = (p < n + 1) ? 0 : 1;
      q  = p % (n + 1);
      chk("R8", $sformatf("sck fmt %0d c %0d", f, c), sck, (c % 2) ^ sck_pol);
      chk("R7", $sformatf("sfs fmt %0d c %0d", f, c), sfs, (q == 0) ^ fs_pol);
      chk("R7", $sformatf("sdat fmt %0d c %0d", f, c), sdat, (q == 0) ? 0 : w[wd][32 - q]);
      if (c == inj) begin in_i = vnew; in_q = ~vnew; in_vld = 1'b1; end
      else in_vld = 1'b0;
      @(negedge clk);
    end
    in_vld = 1'b0;
    chk("R8", "sck idle", sck, sck_pol);
    chk("R8", "sfs idle", sfs, fs_pol);
    chk("R7", "sdat idle", sdat, 0);
    if (inj >= 0) begin
      psel = 3'd0; #1;
      chk("R9", "parallel updated during transfer", pout, exp_word(f, vnew) >> 16);
    end
  endtask

  logic [IN_W-1:0] vals [44];
  logic [IN_W-1:0] lfsr;

  initial begin
    vals[0]  = '0;
    vals[1]  = 36'd1;
    vals[2]  = '1;
    vals[3]  = {1'b0, {35{1'b1}}};
    vals[4]  = {1'b1, 35'd0};
    vals[5]  = 36'h0_0008_0000;   // 16-bit half exactly
    vals[6]  = 36'h0_0007_FFFF;
    vals[7]  = 36'hF_FFF8_0000;   // negative half
    vals[8]  = 36'hF_FFF7_FFFF;
    vals[9]  = 36'h0_0000_0800;   // 24-bit half exactly
    vals[10] = 36'h0_0000_07FF;
    vals[11] = 36'h7_FFF8_0000;   // 16-bit saturation
    vals[12] = 36'h7_FFF7_FFFF;
    vals[13] = 36'h7_FFFF_F800;   // 24-bit saturation
    vals[14] = 36'h7_FFFF_F7FF;
    vals[15] = 36'h0_0004_0000;   // float: shift beyond cap
    vals[16] = 36'h0_0100_0000;
    vals[17] = 36'hF_FFC0_0000;
    vals[18] = 36'h4_0000_0000;
    vals[19] = 36'hC_0000_0000;
    lfsr = 36'h9_A3C5_E171;
    for (int k = 20; k < 44; k++) begin
      lfsr = {lfsr[34:0], lfsr[35] ^ lfsr[24]};
      lfsr = lfsr ^ (lfsr << 7) ^ (lfsr >> 5);
      vals[k] = lfsr >> (k % 20);
      if (k % 3 == 0) vals[k] = ~vals[k];
    end

    repeat (3) @(negedge clk);
    // reset state
    chk("R6", "reset rdy", rdy, 0);
    chk("R8", "reset sck", sck, 0);
    chk("R8", "reset sfs", sfs, 0);
    chk("R6", "reset pout", pout, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // sweep formats and values, parallel port
    for (int f = 0; f < 8; f++)
      for (int k = 0; k < 44; k++)
        par_check(f, vals[k], vals[(k + 7) % 44]);

    // ready polarity
    rdy_pol = 1'b1;
    @(negedge clk);
    chk("R8", "rdy inverted idle", rdy, 1);
    par_check(3, vals[5], vals[11]);
    rdy_pol = 1'b0;

    // serial transfers for every length and polarity mix
    for (int f = 0; f < 6; f++) begin
      sck_pol = f[0];
      fs_pol  = f[1];
      @(negedge clk);
      ser_check(f, vals[20 + f], vals[30 + f], -1, '0);
      repeat (2) @(negedge clk);
    end
    sck_pol = 1'b0; fs_pol = 1'b0;

    // capture while a transfer runs
    ser_check(4, vals[21], vals[22], 5, vals[40]);
    repeat (2) @(negedge clk);

    // serial disabled
    ser_en = 1'b0; sck_pol = 1'b1; fs_pol = 1'b1;
    @(negedge clk);
    fmt_sel = 3'd1; in_i = vals[25]; in_vld = 1'b1;
    @(negedge clk);
    in_vld = 1'b0;
    for (int c = 0; c < 12; c++) begin
      chk("R9", "sck quiet when disabled", sck, 1);
      chk("R9", "sfs quiet when disabled", sfs, 1);
      chk("R9", "sdat quiet when disabled", sdat, 0);
      @(negedge clk);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule